// File: doc/BRIEF.md
# Two-Wire Bus Master Controller with Arbitration Fallback

This block is the master side of a two-wire serial bus controller (I2C style). Software talks to it through a byte-wide register port with write and read strobes. It can open a transfer with a START condition, and it can reopen one with a repeated START without releasing the bus. It shifts address and data bytes out MSB first and samples the acknowledge bit. It can also receive bytes and return an acknowledge or a not-acknowledge. It closes a transfer with a STOP. After every byte it raises an interrupt and holds SCL low until software touches the data register again. The open-drain pads appear as output-enable pins (1 pulls the line low) and input pins that read the wired line.

The controller watches the bus all the time and tracks whether any master owns it. Arbitration is lost when the block releases SDA for a 1 but reads a 0 while SCL is high. At that point it stops driving SDA at once and drops to slave-receive. It keeps clocking to the end of the byte and interrupts on the falling edge of the ninth clock. A START that software requests while another master holds the bus is refused: no condition of any kind goes onto the wires, and software is told through the arbitration-lost flag. The SCL timing comes from a programmable divider, and the high phase is timed only once SCL actually reads high.

Register map (2-bit address): 0 control, 1 status, 2 data, 3 divider. Control: bit 7 enable, bit 5 master, bit 4 transmit (1) / receive (0), bit 3 no-acknowledge, bit 2 repeated-start request (write-only, self-clearing). Status: bit 7 shifter idle, bit 5 bus busy, bit 4 arbitration lost, bit 1 interrupt pending, bit 0 received acknowledge (1 = not acknowledged).

Top module: `i2c_arb_master`

## Requirements
- R1: After reset the control register reads 0x00, status reads 0x80, the divider reads DIV_RESET, irq is 0, and neither pad enable is asserted.
- R2: Writing control with enable and master set (master previously 0) while the bus is free produces a START (SDA falls while SCL is high), sets busy (status bit 5), and leaves SCL held low.
- R3: Writing the data register while holding the bus sends the byte MSB first over 9 SCL clocks, keeps SDA steady while SCL is high, stores the sampled acknowledge in status bit 0 (0 = acknowledged), sets irq on the ninth clock, and then holds SCL low.
- R4: Clearing the master bit while holding the bus produces a STOP (SDA rises while SCL is high) and clears busy.
- R5: Writing control with master and repeated-start set while holding the bus produces a new START with no STOP in between.
- R6: In receive mode, a read of the data register starts a byte. The master drives the ninth bit low unless no-acknowledge (control bit 3) is set, and the data register returns the received byte.
- R7: If the block releases SDA during a transmitted data bit but reads it low while SCL is high, it releases SDA from then on, sets arbitration-lost (status bit 4), and clears the master and transmit bits.
- R8: After a loss, SCL keeps toggling to the end of the byte: exactly 9 rising edges. irq is set as SCL falls after the ninth high phase, and after one low phase SCL is released.
- R9: A master-bit set written while the bus is busy drives neither pad, emits no START or STOP, leaves the master bit 0, and sets arbitration-lost and irq.
- R10: Writing 0 to status bit 1 or bit 4 clears that flag. Writing 1 leaves it unchanged.
- R11: Busy is set by any START and cleared by any STOP seen on the lines, including those from other masters.
- R12: Each SCL high phase lasts divider+1 clock cycles counted from when SCL reads high, so a slave holding SCL low does not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt pending |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Wired SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Wired SDA level |

## Verification
The hardest state to reach is a lost arbitration in the middle of a byte, because it needs a second party to pull SDA low just when this block has released it. The bench models that master as an extra open-drain pull. It asserts the pull while SCL is low after a START and then sends a byte whose first bit is 1. Clock stretching is produced the same way, by holding SCL low through a high phase the controller has already entered. A small slave model that only follows SCL edges supplies the acknowledge and the read data.

// File: rtl/i2c_arb_master.sv
module i2c_arb_master #(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [1:0] A_CTL = 2'd0, A_STS = 2'd1, A_DAT = 2'd2, A_DIV = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_STA1, S_STA2, S_HOLD, S_LOW, S_HIGH, S_LOSE, S_RS1, S_STP1, S_STP2, S_STP3
  } st_t;

  st_t             st;
  logic [DIV_W-1:0] cnt, div;
  logic en, mst, tx, noack, busy, arbl, irqf, rxack, lost, sda_q, scl_p, sda_p;
  logic [7:0] shreg;
  logic [3:0] bitn;

  wire wr_ctl = reg_wr & (reg_addr == A_CTL);
  wire wr_sts = reg_wr & (reg_addr == A_STS);
  wire wr_dat = reg_wr & (reg_addr == A_DAT);
  wire wr_div = reg_wr & (reg_addr == A_DIV);
  wire rd_dat = reg_rd & (reg_addr == A_DAT);

  wire tick     = (cnt == div);
  wire run      = !(st == S_HIGH || st == S_STA1 || st == S_STP2) || scl_in;
  wire shifting = (st == S_LOW) || (st == S_HIGH);
  wire last_bit = (bitn == 4'd8);
  wire start_seen = scl_p & scl_in & sda_p & ~sda_in;
  wire stop_seen  = scl_p & scl_in & ~sda_p & sda_in;
  wire arb_hit = (st == S_HIGH) & tx & ~last_bit & ~lost & ~sda_q & scl_in & ~sda_in;

  logic sda_want;
  always_comb begin
    case (st)
      S_STA2, S_STP1, S_STP2: sda_want = 1'b1;
      S_LOW, S_HIGH:          sda_want = ~lost & (last_bit ? (~tx & ~noack) : (tx & ~shreg[7]));
      default:                sda_want = 1'b0;
    endcase
  end

  assign scl_oe = (st == S_HOLD) || (st == S_LOW) || (st == S_LOSE) || (st == S_RS1) || (st == S_STP1);
  assign sda_oe = sda_q;
  assign irq    = irqf;

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {en, 1'b0, mst, tx, noack, 3'b000};
      A_STS:   reg_rdata = {~shifting, 1'b0, busy, arbl, 2'b00, irqf, rxack};
      A_DAT:   reg_rdata = shreg;
      default: reg_rdata = 8'(div);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; div <= DIV_W'(DIV_RESET);
      en <= 1'b0; mst <= 1'b0; tx <= 1'b0; noack <= 1'b0;
      busy <= 1'b0; arbl <= 1'b0; irqf <= 1'b0; rxack <= 1'b0; lost <= 1'b0;
      shreg <= '0; bitn <= '0; sda_q <= 1'b0; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_p <= scl_in;
      sda_p <= sda_in;
      sda_q <= sda_want;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
      if (run) cnt <= cnt + DIV_W'(1);

      if (wr_div) div <= reg_wdata[DIV_W-1:0];
      if (wr_sts) begin
        arbl <= arbl & reg_wdata[4];
        irqf <= irqf & reg_wdata[1];
      end
      if (wr_ctl) begin
        en <= reg_wdata[7]; tx <= reg_wdata[4]; noack <= reg_wdata[3];
        if (reg_wdata[5] && !mst) begin
          if (reg_wdata[7] && busy) begin
            arbl <= 1'b1;
            irqf <= 1'b1;
          end else if (reg_wdata[7] && st == S_IDLE) begin
            mst <= 1'b1; st <= S_STA1; cnt <= '0;
          end
        end else if (!reg_wdata[5] && mst) begin
          mst <= 1'b0;
        end else if (reg_wdata[5] && reg_wdata[2] && st == S_HOLD) begin
          st <= S_RS1; cnt <= '0;
        end
      end

      case (st)
        S_STA1: if (tick) begin st <= S_STA2; cnt <= '0; end
        S_STA2: if (tick) begin st <= S_HOLD; cnt <= '0; bitn <= '0; end
        S_HOLD: begin
          if (!mst) begin
            st <= S_STP1; cnt <= '0;
          end else if (wr_dat) begin
            shreg <= reg_wdata; bitn <= '0; st <= S_LOW; cnt <= '0;
          end else if (rd_dat && !tx) begin
            bitn <= '0; st <= S_LOW; cnt <= '0;
          end
        end
        S_LOW: if (tick) begin st <= S_HIGH; cnt <= '0; end
        S_HIGH: begin
          if (arb_hit) begin
            lost <= 1'b1; mst <= 1'b0; tx <= 1'b0; arbl <= 1'b1;
          end
          if (tick) begin
            cnt <= '0;
            if (!last_bit) begin
              shreg <= {shreg[6:0], sda_in};
              bitn  <= bitn + 4'd1;
              st    <= S_LOW;
            end else begin
              if (tx && !lost) rxack <= sda_in;
              irqf <= 1'b1;
              st   <= (lost || arb_hit) ? S_LOSE : S_HOLD;
            end
          end
        end
        S_LOSE: if (tick) begin st <= S_IDLE; lost <= 1'b0; cnt <= '0; end
        S_RS1:  if (tick) begin st <= S_STA1; cnt <= '0; end
        S_STP1: if (tick) begin st <= S_STP2; cnt <= '0; end
        S_STP2: if (tick) begin st <= S_STP3; cnt <= '0; end
        S_STP3: if (tick) begin st <= S_IDLE; cnt <= '0; end
        default: ;
      endcase
    end
  end

  a_r7_lost_sda_off: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !sda_oe);
  a_r7_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit |=> (arbl && !mst));
  a_r9_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[7] && reg_wdata[5] && !mst && busy) |=> (!mst && arbl && irq));
  a_r11_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy);
  a_r11_busy_clr: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !busy);
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) == S_HIGH && !lost && !$past(lost) && !$past(wr_ctl))
      |-> $stable(sda_oe));
endmodule

// File: tb/tb_i2c_arb_master.sv
module tb_i2c_arb_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic irq, scl_oe, sda_oe, scl_in, sda_in;
  logic ext_scl = 1'b0, ext_sda = 1'b0, ack_en = 1'b0, slv_tx = 1'b0;
  logic [7:0] txb = 8'h00;

  always #5 clk = ~clk;

  i2c_arb_master #(.DIV_W(8), .DIV_RESET(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe), .sda_in(sda_in));

  // bus wiring and a small slave model driven only by SCL edges
  int bcnt = 0, dcnt = 0, starts = 0, stops = 0, rises = 0, oe_total = 0, hcnt = 0;
  int hl [64];
  logic [7:0] cap = 8'h00;
  logic ackseen = 1'b0, scl_q = 1'b1, sda_q = 1'b1;
  wire ack_drv  = ack_en & ~slv_tx & (dcnt == 8);
  wire data_drv = slv_tx & (dcnt < 8) & ~txb[7 - (dcnt % 8)];
  assign scl_in = ~(scl_oe | ext_scl);
  assign sda_in = ~(sda_oe | ext_sda | ack_drv | data_drv);

  always @(posedge clk) begin
    scl_q <= scl_in;
    sda_q <= sda_in;
    if (sda_oe) oe_total <= oe_total + 1;
    if (scl_in) hcnt <= hcnt + 1;
    if (scl_q && scl_in && sda_q && !sda_in) begin starts <= starts + 1; bcnt <= 0; dcnt <= 0; end
    if (scl_q && scl_in && !sda_q && sda_in) stops <= stops + 1;
    if (!scl_q && scl_in) begin
      if (bcnt < 8) cap <= {cap[6:0], sda_in};
      else if (bcnt == 8) ackseen <= sda_in;
      bcnt <= bcnt + 1;
      rises <= rises + 1;
    end
    if (scl_q && !scl_in) begin
      hl[rises % 64] <= hcnt;
      hcnt <= 0;
      if (bcnt >= 9) begin bcnt <= 0; dcnt <= 0; end
      else dcnt <= bcnt;
    end
  end

  int tests = 0, fails = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    if (!irq) check(req, 0, 1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {slave acknowledges, byte}
  localparam logic [8:0] VEC [4] = '{9'h15A, 9'h0FF, 9'h100, 9'h181};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int r0, s0, p0, o0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h80);
    rd(2'd3, v); check("R1 divider", v, 4);
    check("R1 pads", {scl_oe, sda_oe, irq}, 0);

    // R2 start
    wr(2'd0, 8'hB0);
    idle(30);
    check("R2 start seen", starts, 1);
    rd(2'd1, v); check("R2 busy", v[5], 1);
    check("R2 scl held", scl_in, 0);

    // R3 table of transmitted bytes
    foreach (VEC[i]) begin
      ack_en = VEC[i][8];
      r0 = rises;
      wr(2'd2, VEC[i][7:0]);
      wait_irq("R3 irq");
      check("R3 byte on wire", cap, VEC[i][7:0]);
      check("R3 nine clocks", rises - r0, 9);
      rd(2'd1, v); check("R3 ack bit", v[0], !VEC[i][8]);
      idle(20);
      check("R3 scl held low", scl_in, 0);
      wr(2'd1, 8'h00);
      check("R10 irq cleared", irq, 0);
    end

    // R5 repeated start, then address for read
    ack_en = 1'b1;
    wr(2'd0, 8'hB4);
    idle(40);
    check("R5 second start", starts, 2);
    check("R5 no stop", stops, 0);
    wr(2'd2, 8'hA1);
    wait_irq("R5 irq");
    check("R5 address", cap, 8'hA1);
    wr(2'd1, 8'h00);

    // R6 receive two bytes: acked then not acked
    wr(2'd0, 8'hA0);
    txb = 8'h3C; slv_tx = 1'b1;
    rd(2'd2, v);
    wait_irq("R6 irq 1");
    txb = 8'hA5;
    check("R6 master ack", ackseen, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hA8);
    rd(2'd2, v); check("R6 first byte", v, 8'h3C);
    wait_irq("R6 irq 2");
    slv_tx = 1'b0;
    check("R6 master nack", ackseen, 1);
    wr(2'd1, 8'h00);

    // R4 stop
    wr(2'd0, 8'h80);
    idle(40);
    check("R4 stop seen", stops, 1);
    rd(2'd1, v); check("R4 busy clear", v[5], 0);
    rd(2'd2, v); check("R6 second byte", v, 8'hA5);

    // R12 stretched high phase
    wr(2'd3, 8'd6);
    wr(2'd0, 8'hB0);
    idle(40);
    ext_scl = 1'b1;
    r0 = rises;
    wr(2'd2, 8'h96);
    idle(40);
    ext_scl = 1'b0;
    wait_irq("R12 irq");
    check("R12 byte", cap, 8'h96);
    begin
      int bad = 0;
      idle(2);
      for (int k = 1; k <= 9; k++) if (hl[(r0 + k) % 64] != 7) bad++;
      check("R12 high phases", bad, 0);
    end
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h80);
    idle(60);
    wr(2'd3, 8'd4);

    // R7/R8 arbitration loss mid-byte
    wr(2'd0, 8'hB0);
    idle(30);
    ack_en = 1'b0;
    ext_sda = 1'b1;
    r0 = rises; o0 = oe_total;
    wr(2'd2, 8'hC3);
    wait_irq("R8 irq");
    check("R8 nine clocks", rises - r0, 9);
    check("R8 scl low at irq", scl_in, 0);
    check("R7 sda released", oe_total - o0, 0);
    rd(2'd1, v); check("R7 lost flag", v[4], 1);
    rd(2'd0, v); check("R7 master and tx cleared", v[5:4], 0);
    idle(20);
    check("R8 scl released", scl_oe, 0);
    rd(2'd1, v); check("R11 busy held", v[5], 1);
    ext_sda = 1'b0;
    idle(5);
    rd(2'd1, v); check("R11 external stop", v[5], 0);
    wr(2'd1, 8'hFF);
    rd(2'd1, v); check("R10 write one keeps", v[4] & v[1], 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R10 write zero clears", {v[4], v[1]}, 0);

    // R9 blocked start on busy bus
    ext_sda = 1'b1;
    idle(5);
    rd(2'd1, v); check("R11 external start", v[5], 1);
    s0 = starts; p0 = stops; o0 = oe_total;
    wr(2'd0, 8'hB0);
    idle(30);
    rd(2'd0, v); check("R9 master stays 0", v[5], 0);
    rd(2'd1, v); check("R9 flags", {v[4], v[1]}, 3);
    check("R9 irq", irq, 1);
    check("R9 no conditions", (starts - s0) + (stops - p0), 0);
    check("R9 pads idle", (oe_total - o0) + scl_oe, 0);
    ext_sda = 1'b0;
    idle(5);
    wr(2'd1, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule